// File: doc/BRIEF.md
# Latched Address One-Cold Decoder

This block turns a binary address into a single active-low select line out of 2^ADDR_W lines (sixteen at the default width). The address passes through a hold register. While the load control is high, the register takes a new address on every rising clock edge. While the load control is low, the register keeps its value, and later changes on the address pins have no effect.

A separate active-low enable gates the outputs combinationally. When the enable is low, the line whose index equals the held address goes low. When the enable is high, every line is high. The enable never changes the held address. Because of this, the block can also serve as a 1-to-N demultiplexer. The enable pin carries a serial data stream, and the held address picks which output line reproduces that stream, with the same polarity as the enable pin.

Top module: `latched_onecold_decoder`

## Requirements
- R1: While rstN is low, the held address is zero. With enableN low, selN is then all ones except bit 0, which is low.
- R2: On a rising clk edge with latchEn high, the held address takes the value of addrIn. addrIn bit 0 is the least significant bit. The new value shows on selN right after that edge.
- R3: On a rising clk edge with latchEn low, the held address keeps its value. Changes on addrIn while latchEn is low do not alter selN.
- R4: While enableN is low, selN bit k is low exactly when k equals the held address, and every other bit is high.
- R5: While enableN is high, all bits of selN are high, whatever addrIn, latchEn or the held address are.
- R6: enableN has no effect on the held address. Toggling it while latchEn is low leaves the same line selected once enableN returns low.
- R7: With an address held, the selected bit of selN follows enableN in the same cycle, with no clock delay, and all other bits stay high (demultiplexer use).
- R8: At most one bit of selN is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the hold register samples on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears the held address |
| addrIn | input | ADDR_W | Binary address, bit 0 least significant |
| latchEn | input | 1 | High: load addrIn each edge; low: keep the held address |
| enableN | input | 1 | Active-low output enable; also the data input in demultiplexer use |
| selN | output | 2^ADDR_W | Active-low one-cold select lines |

## Verification
On every cycle, the assertions check the one-cold property, that the outputs are all high while the enable is high, the address loaded on an edge with latchEn high, and output stability across edges with latchEn low. They also check the reset value. Only the bench's scenarios can show the following. After the enable has been toggled while latched, the same line comes back. Every one of the sixteen addresses decodes to its own line. A serial pattern on the enable appears, in the same cycle, on only the held line.

// File: rtl/lat_dec_pkg.sv
package lat_dec_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic loadAddr;   // capture the address on this edge
    logic driveOut;   // let the decoded line go low
  } decStrobes_t;

  function automatic int unsigned lineCount(input int unsigned addrWidth);
    return 32'd1 << addrWidth;
  endfunction

endpackage

// File: rtl/lat_dec_ctrl.sv
module lat_dec_ctrl
  import lat_dec_pkg::*;
(
  input  logic        latchEn,
  input  logic        enableN,
  output decStrobes_t strobes
);

  // The enable only gates the outputs; it never feeds the load path.
  always_comb begin
    strobes.loadAddr = latchEn;
    strobes.driveOut = ~enableN;
  end

endmodule

// File: rtl/lat_dec_datapath.sv
module lat_dec_datapath
  import lat_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  decStrobes_t       strobes,
  output logic [OUT_N-1:0]  selN
);

  logic [ADDR_W-1:0] heldAddr;
  logic [OUT_N-1:0]  hotLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
    end else if (strobes.loadAddr) begin
      heldAddr <= addrIn;
    end
  end

  // One comparator per output line; the enable gate sits after the decode.
  for (genvar lineIdx = 0; lineIdx < OUT_N; lineIdx++) begin : g_line
    assign hotLine[lineIdx] = (heldAddr == ADDR_W'(lineIdx));
    assign selN[lineIdx]    = ~(hotLine[lineIdx] & strobes.driveOut);
  end

endmodule

// File: rtl/latched_onecold_decoder.sv
module latched_onecold_decoder
  import lat_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              latchEn,
  input  logic              enableN,
  output logic [OUT_N-1:0]  selN
);

  decStrobes_t strobes;

  lat_dec_ctrl ctrl_i (
    .latchEn (latchEn),
    .enableN (enableN),
    .strobes (strobes)
  );

  lat_dec_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .strobes (strobes),
    .selN    (selN)
  );

endmodule

// File: rtl/latched_onecold_decoder_chk.sv
module latched_onecold_decoder_chk #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              latchEn,
  input logic              enableN,
  input logic [OUT_N-1:0]  selN
);

  localparam logic [OUT_N-1:0] ONE_HOT0 = OUT_N'(1);

  // Set one edge after reset release so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_reset_line0_r1: assert property (@(posedge clk)
    (!rstN && !enableN) |-> (selN == ~ONE_HOT0));

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(latchEn) && !enableN) |-> (selN == ~(ONE_HOT0 << $past(addrIn))));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(latchEn) && !$past(enableN) && !enableN) |-> $stable(selN));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    enableN |-> (selN == '1));

  p_onecold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~selN) <= 1);

  p_active_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enableN |-> ($countones(~selN) == 1));

endmodule

bind latched_onecold_decoder latched_onecold_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .addrIn  (addrIn),
  .latchEn (latchEn),
  .enableN (enableN),
  .selN    (selN)
);

// File: tb/latched_onecold_decoder_tb_top.sv
module latched_onecold_decoder_tb_top;

  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned OUT_N     = 1 << ADDR_W;
  localparam time         CLK_PER   = 10ns;
  localparam int          WATCHDOG  = 200000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              latchEn = 1'b0;
  logic              enableN = 1'b0;
  logic [OUT_N-1:0]  selN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  latched_onecold_decoder #(.ADDR_W(ADDR_W)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .latchEn (latchEn),
    .enableN (enableN),
    .selN    (selN)
  );

  function automatic logic [OUT_N-1:0] expSel(input int idx, input bit en);
    logic [OUT_N-1:0] v = '1;
    if (en) v[idx] = 1'b0;
    return v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [OUT_N-1:0] act, input logic [OUT_N-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive after the falling edge, let one rising edge pass, sample 1ns later.
  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  // R8 watched on every falling edge
  always @(negedge clk) begin
    if (rstN && !finished) check($countones(~selN) <= 1, "R8", selN, selN);
  end

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0; enableN = 1'b0; latchEn = 1'b0;
    #1;
    check(selN == expSel(0, 1), "R1", selN, expSel(0, 1));
    stepEdge();
    check(selN == expSel(0, 1), "R1", selN, expSel(0, 1));
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tSweep();
    for (int a = 0; a < OUT_N; a++) begin
      @(negedge clk);
      latchEn = 1'b1; enableN = 1'b0; addrIn = ADDR_W'(a);
      stepEdge();
      check(selN == expSel(a, 1), "R2/R4", selN, expSel(a, 1));
      enableN = 1'b1;
      #1;
      check(selN == '1, "R5", selN, '1);
    end
  endtask

  task automatic tHold();
    @(negedge clk);
    latchEn = 1'b1; enableN = 1'b0; addrIn = 4'd5;
    stepEdge();
    @(negedge clk);
    latchEn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      addrIn = ADDR_W'(9 + k);
      stepEdge();
      check(selN == expSel(5, 1), "R3", selN, expSel(5, 1));
    end
  endtask

  task automatic tEnableToggle();
    @(negedge clk);
    latchEn = 1'b1; enableN = 1'b0; addrIn = 4'd12;
    stepEdge();
    @(negedge clk);
    latchEn = 1'b0; addrIn = 4'd3;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      enableN = ~enableN;
      stepEdge();
    end
    @(negedge clk);
    enableN = 1'b0;
    stepEdge();
    check(selN == expSel(12, 1), "R6", selN, expSel(12, 1));
  endtask

  task automatic tDemux();
    logic [7:0] pattern = 8'b1011_0010;
    @(negedge clk);
    latchEn = 1'b1; enableN = 1'b1; addrIn = 4'd11;
    stepEdge();
    @(negedge clk);
    latchEn = 1'b0;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      enableN = pattern[b];
      #1;
      check(selN == expSel(11, !pattern[b]), "R7", selN, expSel(11, !pattern[b]));
    end
  endtask

  task automatic tResetAfterLoad();
    @(negedge clk);
    latchEn = 1'b1; enableN = 1'b0; addrIn = 4'd7;
    stepEdge();
    check(selN == expSel(7, 1), "R2", selN, expSel(7, 1));
    tReset();
  endtask

  task automatic finish();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PER * WATCHDOG);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    tReset();
    tSweep();
    tHold();
    tEnableToggle();
    tDemux();
    tResetAfterLoad();
    repeat (2) @(negedge clk);
    finish();
  end

endmodule